// File: doc/BRIEF.md
# Register-launched APB access bridge

This block lets a host run single 32-bit APB transfers by writing one 64-bit command word. The word holds a start flag, a direction flag, a word address, an error flag and a 32-bit data field. A host write that sets the start flag latches the command and launches one APB transfer. The block then runs a setup cycle and an access phase, and waits for the slave to signal ready. When the transfer ends, the block clears the start flag and writes the slave error response into the word. For a read, it also writes the returned data into the word. The host learns that the transfer is complete by reading the word until the start flag reads 0.

The host port is a plain register port with no back-pressure. A write strobe carries a full 64-bit word, and the current word can be read combinationally at any time. The block has one valid/ready style exchange, on the APB side: the access phase holds `psel`, `penable`, `paddr`, `pwrite` and `pwdata` steady until the slave raises `pready`. The slave can stretch a transfer by any number of cycles.

The word address can also carry a cluster tile number. Word-address bits 27:24 hold the tile. When the tile is nonzero, the bridge forces word-address bit 28 to 1. Tile 0 addresses the root region and is passed through unchanged.

Top module: `apb_cmd_bridge`

## Requirements
- R1: A host write with bit 0 set, made while bit 0 reads 0, launches one transfer. Bit 0 reads 1 from the cycle after that write until the clock edge at which the access phase completes, and reads 0 from then on.
- R2: Bit 1 of the command selects the direction: 0 is a write and 1 is a read. During the transfer, `pwrite` equals the inverse of bit 1. `pwdata` equals command bits 63:32.
- R3: `paddr` is the stored word address (command bits 30:2) shifted left by two. Bit 31 of `paddr` is 0.
- R4: When word-address bits 27:24 (command bits 29:26) are nonzero, the stored word address has bit 28 set (command bit 30, `paddr` bit 30), and the readback shows it set. When the tile is 0, the address is kept exactly as written.
- R5: Every transfer begins with exactly one setup cycle (`psel`=1, `penable`=0). The next cycle is the access phase (`psel`=1, `penable`=1).
- R6: The access phase lasts until `pready` is 1. While it lasts, `paddr`, `pwrite` and `pwdata` stay stable.
- R7: A read stores `prdata`, sampled in the completing cycle, into bits 63:32. A write leaves bits 63:32 holding the write data. The data field then stays stable until the next launch.
- R8: `pslverr`, sampled in the completing cycle, is stored in bit 31. A launch clears bit 31, whatever value the host wrote there.
- R9: A host write that arrives while bit 0 reads 1 is ignored. The transfer in flight keeps its address, direction and data, and no extra transfer follows.
- R10: A host write with bit 0 clear, made while idle, changes nothing: the readback word is unchanged and no transfer starts.
- R11: After reset, the word reads all zeros and `psel` and `penable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command/status word |
| paddr | output | 32 | APB byte address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (access phase) |
| pwrite | output | 1 | APB direction, 1 for write |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB slave ready |
| pslverr | input | 1 | APB slave error |

## Verification
The hardest case to reach is a host write that lands during a transfer that is still in flight. To reach it, the bench slave model stretches the access phase with several wait cycles. While those cycles run, the bench writes a second, different launch command. The scoreboard then confirms three things: the bus fields stay those of the first command, the final word is the one expected for the first command, and no second setup cycle appears. The error path is driven by a slave that answers with an error. A following launch with bit 31 set in the host data must complete with bit 31 cleared.

// File: rtl/apb_cmd_pkg.sv
package apb_cmd_pkg;
  localparam int CMD_W     = 64;
  localparam int DATA_W    = 32;
  localparam int WADDR_W   = 29;
  localparam int TILE_LSB  = 24;
  localparam int TILE_W    = 4;
  localparam int MARK_BIT  = 28;
  localparam int START_BIT = 0;
  localparam int DIR_BIT   = 1;
  localparam int ADDR_LSB  = 2;
  localparam int ERR_BIT   = 31;
  localparam int DATA_LSB  = 32;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACCESS} phase_t;

  function automatic logic [WADDR_W-1:0] apply_mark(input logic [WADDR_W-1:0] a);
    logic [WADDR_W-1:0] r;
    r = a;
    if (a[TILE_LSB +: TILE_W] != '0) r[MARK_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/apb_cmd_word.sv
module apb_cmd_word
  import apb_cmd_pkg::*;
#(
  parameter bit MARK_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CMD_W-1:0]   wdata,
  input  logic               done,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic               slv_err,
  output logic               launch,
  output logic               dir_rd,
  output logic [WADDR_W-1:0] waddr,
  output logic [DATA_W-1:0]  data,
  output logic [CMD_W-1:0]   word
);
  logic               start_q, dir_q, err_q;
  logic [WADDR_W-1:0] waddr_q, waddr_in;
  logic [DATA_W-1:0]  data_q;
  logic               unused_err_in;

  assign unused_err_in = wdata[ERR_BIT];

  generate
    if (MARK_EN) begin : g_mark
      assign waddr_in = apply_mark(wdata[ADDR_LSB +: WADDR_W]);
    end else begin : g_plain
      assign waddr_in = wdata[ADDR_LSB +: WADDR_W];
    end
  endgenerate

  assign launch = wr_en && wdata[START_BIT] && !start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
      waddr_q <= '0;
      data_q  <= '0;
    end else if (launch) begin
      start_q <= 1'b1;
      dir_q   <= wdata[DIR_BIT];
      err_q   <= 1'b0;
      waddr_q <= waddr_in;
      data_q  <= wdata[DATA_LSB +: DATA_W];
    end else if (done) begin
      start_q <= 1'b0;
      err_q   <= slv_err;
      if (dir_q) data_q <= rd_data;
    end
  end

  assign dir_rd = dir_q;
  assign waddr  = waddr_q;
  assign data   = data_q;
  assign word   = {data_q, err_q, waddr_q, dir_q, start_q};

  AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && !done |=> start_q && $stable(waddr_q) && $stable(dir_q) && $stable(data_q)); // R9
  AST_IDLE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q && !launch |=> $stable(data_q) && $stable(err_q)); // R7
  AST_LAUNCH_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !err_q); // R8
endmodule

// File: rtl/apb_cmd_fsm.sv
module apb_cmd_fsm
  import apb_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic pready,
  output logic psel,
  output logic penable,
  output logic done
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:   if (launch) ph_d = PH_SETUP;
      PH_SETUP:  ph_d = PH_ACCESS;
      PH_ACCESS: if (pready) ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign psel    = (ph_q != PH_IDLE);
  assign penable = (ph_q == PH_ACCESS);
  assign done    = penable && pready;

  AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel); // R5
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(penable) |-> $past(psel) && !$past(penable)); // R5
  AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    psel && !penable |=> psel && penable); // R5
  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    psel && penable && !pready |=> psel && penable); // R6
endmodule

// File: rtl/apb_cmd_bridge.sv
module apb_cmd_bridge
  import apb_cmd_pkg::*;
#(
  parameter int PADDR_W = 32,
  parameter bit MARK_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [CMD_W-1:0]   host_wdata,
  output logic [CMD_W-1:0]   host_rdata,
  output logic [PADDR_W-1:0] paddr,
  output logic               psel,
  output logic               penable,
  output logic               pwrite,
  output logic [DATA_W-1:0]  pwdata,
  input  logic [DATA_W-1:0]  prdata,
  input  logic               pready,
  input  logic               pslverr
);
  localparam int PAD_W = PADDR_W - WADDR_W - 2;

  logic               launch, done, dir_rd;
  logic [WADDR_W-1:0] waddr;
  logic [DATA_W-1:0]  data;

  apb_cmd_word #(.MARK_EN(MARK_EN)) u_word (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .wdata(host_wdata),
    .done(done), .rd_data(prdata), .slv_err(pslverr), .launch(launch),
    .dir_rd(dir_rd), .waddr(waddr), .data(data), .word(host_rdata)
  );

  apb_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .launch(launch), .pready(pready),
    .psel(psel), .penable(penable), .done(done)
  );

  assign paddr  = {{PAD_W{1'b0}}, waddr, 2'b00};
  assign pwrite = !dir_rd;
  assign pwdata = data;

  AST_SEL_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> host_rdata[START_BIT]); // R1
  AST_DONE_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
    psel && penable && pready |=> !host_rdata[START_BIT]); // R1
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    psel && penable && !pready |=> $stable(paddr) && $stable(pwrite) && $stable(pwdata)); // R6

  generate
    if (MARK_EN) begin : g_mark_chk
      AST_TILE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        psel && (paddr[TILE_LSB+2 +: TILE_W] != '0) |-> paddr[MARK_BIT+2]); // R4
    end
  endgenerate
endmodule

// File: tb/apb_cmd_bridge_test.sv
`timescale 1ns/1ps
module apb_cmd_bridge_test;
  typedef struct packed {
    logic [31:0] pa;
    logic        pw;
    logic [31:0] pd;
    logic [63:0] fin;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic [31:0] paddr, pwdata;
  logic [31:0] prdata = '0;
  logic        psel, penable, pwrite;
  logic        pready = 1'b0;
  logic        pslverr = 1'b0;

  int   n_chk = 0, n_bad = 0, cyc = 0, setups = 0, wcnt = 0, slv_wait = 0;
  bit   setup_seen = 0, fin_pending = 0, stop_now = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  apb_cmd_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] d, input logic [28:0] wa, input bit rd);
    return {d, 1'b0, wa, rd, 1'b1};
  endfunction

  function automatic logic [28:0] fwa(input logic [63:0] c);
    logic [28:0] a;
    a = c[30:2];
    if (a[27:24] != 4'd0) a[28] = 1'b1;
    return a;
  endfunction

  task automatic push_exp(input logic [63:0] c, input logic [31:0] rd, input bit err);
    exp_t e;
    e.pa  = {1'b0, fwa(c), 2'b00};
    e.pw  = ~c[1];
    e.pd  = c[63:32];
    e.fin = {(c[1] ? rd : c[63:32]), err, fwa(c), c[1], 1'b0};
    q.push_back(e);
  endtask

  task automatic issue(input logic [63:0] w);
    @(negedge clk);
    host_wr_en = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R1 completion", q.size(), 0);
  endtask

  task automatic run(input logic [63:0] c, input int waits, input logic [31:0] rd, input bit err);
    slv_wait = waits;
    prdata   = rd;
    pslverr  = err;
    push_exp(c, rd, err);
    issue(c);
    drain();
  endtask

  // monitor and slave model
  always @(negedge clk) begin
    if (rst_n) begin
      if (setup_seen) begin
        chk(penable === 1'b1 && psel === 1'b1, "R5 access follows setup", {62'd0, psel, penable}, 64'd3);
        setup_seen = 0;
      end
      if (fin_pending) begin
        if (q.size() > 0) begin
          chk(host_rdata === q[0].fin, "R1 R7 R8 final word", host_rdata, q[0].fin);
          void'(q.pop_front());
        end
        fin_pending = 0;
      end
      if (psel && !penable) begin
        setups++;
        setup_seen = 1;
        if (q.size() > 0) begin
          chk(paddr === q[0].pa, "R3 R4 paddr", {32'd0, paddr}, {32'd0, q[0].pa});
          chk(pwrite === q[0].pw, "R2 pwrite", {63'd0, pwrite}, {63'd0, q[0].pw});
          chk(pwdata === q[0].pd, "R2 pwdata", {32'd0, pwdata}, {32'd0, q[0].pd});
        end else chk(1'b0, "R9 unexpected transfer", {32'd0, paddr}, 64'd0);
      end
      if (psel) chk(host_rdata[0] === 1'b1, "R1 busy during transfer", host_rdata, 64'd1);
      if (psel && penable && !pready && q.size() > 0)
        chk(paddr === q[0].pa && pwdata === q[0].pd, "R6 hold in wait", {32'd0, paddr}, {32'd0, q[0].pa});
      if (psel && penable) begin
        if (wcnt == 0) pready = 1'b1;
        else wcnt--;
      end else begin
        pready = 1'b0;
        wcnt   = slv_wait;
      end
      if (psel && penable && pready) fin_pending = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !stop_now) begin
      stop_now = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] prev, c;
    int s0;
    repeat (3) @(negedge clk);
    chk(host_rdata === 64'd0, "R11 reset word", host_rdata, 64'd0);
    chk(psel === 1'b0 && penable === 1'b0, "R11 bus idle", {62'd0, psel, penable}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(mk(32'hA5A5_0001, 29'h0001234, 1'b0), 0, 32'h0, 1'b0);               // R2 write tile 0
    run(mk(32'h0, (29'd3 << 24) | 29'h55, 1'b1), 2, 32'hCAFE_F00D, 1'b0);    // R4 R7 read tile 3
    run(mk(32'h1357_9BDF, (29'd1 << 28) | (29'd15 << 24) | 29'h3, 1'b0), 1, 32'h0, 1'b0);
    run(mk(32'h0, 29'h00000FF, 1'b1), 0, 32'h0BAD_0BAD, 1'b1);               // R8 error set
    chk(host_rdata[31] === 1'b1, "R8 error flag", host_rdata, 64'h8000_0000);
    c = mk(32'h2468_ACE0, 29'h0000010, 1'b0);
    c[31] = 1'b1;
    run(c, 0, 32'h0, 1'b0);                                                   // R8 launch clears
    chk(host_rdata[31] === 1'b0, "R8 cleared by launch", host_rdata, 64'd0);
    run(mk(32'h0, 29'h1FFF_FFFF, 1'b1), 3, 32'hFFFF_0000, 1'b0);             // R3 top address

    // R9: write during a stretched transfer
    s0 = setups;
    slv_wait = 6;
    prdata = 32'h0;
    pslverr = 1'b0;
    c = mk(32'h1111_2222, 29'h0000AAA, 1'b0);
    push_exp(c, 32'h0, 1'b0);
    issue(c);
    issue(mk(32'h9999_8888, (29'd2 << 24) | 29'h777, 1'b1));
    drain();
    repeat (4) @(negedge clk);
    chk(setups == s0 + 1, "R9 busy write ignored", setups - s0, 1);

    // R10: idle write without start
    prev = host_rdata;
    c = mk(32'h7777_7777, 29'h0000123, 1'b1);
    c[0] = 1'b0;
    issue(c);
    chk(host_rdata === prev, "R10 no-start write ignored", host_rdata, prev);
    repeat (3) begin
      @(negedge clk);
      chk(psel === 1'b0, "R10 no transfer", {63'd0, psel}, 64'd0);
    end
    chk(host_rdata === prev, "R7 data stable when idle", host_rdata, prev);

    stop_now = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule